// File: doc/BRIEF.md
# UART Interrupt Priority Identifier

This block merges the interrupt sources of a UART into one active-high interrupt line and a 4-bit identification code. The code always names just one condition: the most urgent one that is both pending and enabled. Lower-priority conditions stay hidden until every more urgent one has been serviced. The source conditions come from elsewhere in the UART. This block gates them with a 4-bit enable register. It holds the conditions that need an explicit acknowledge and clears each one on the access that services it.

Line-status errors, receive timeouts and modem-status changes are captured on the rising edge of their condition inputs. Each stays pending until its service access: a line-status read, a receive-holding read or a modem-status read. If a new rising edge arrives in the same cycle as the service access, the edge wins. Receive-data-ready is a level and passes straight through. The transmit-empty interrupt is pending from reset. It is cleared by a transmit-holding write, or by an identification read while it is the reported code. It is armed again when the transmitter becomes empty or when its enable bit goes from 0 to 1.

Top module: `uart_irq_ident`

## Requirements
- R1: While reset is held and in the cycles after it, with no source condition high or enabled, `irq` is 0 and `ident` is 4'b0001.
- R2: Enable bit 0 gates both receive sources, bit 1 transmit-empty, bit 2 line status and bit 3 modem status. With all enable bits 0, `ident` is 4'b0001 whatever the conditions are.
- R3: A pending line-status interrupt (enable bit 2) is reported as 4'b0110 ahead of all other sources. A masked lower source becomes visible once it is cleared.
- R4: Receive data ready (enable bit 0) is reported as 4'b0100 when no line-status interrupt is pending.
- R5: Receive timeout shares the receive level and enable bit 0. It is reported as 4'b1100, and it takes the place of 4'b0100 when both receive conditions are pending.
- R6: Transmit-empty (enable bit 1, `tx_empty` high) is reported as 4'b0010 below the receive level. It is pending straight out of reset.
- R7: Modem status (enable bit 3) is the lowest priority and is reported as 4'b0000.
- R8: A line-status interrupt is captured on a rising edge of `line_err` and cleared by `rd_lsr`. A level held high does not capture it again, and a rising edge in the same cycle as the read wins.
- R9: A modem-status interrupt is captured on a rising edge of `modem_chg` and cleared by `rd_msr`.
- R10: A receive timeout is captured on a rising edge of `rx_timeout` and cleared by `rd_rhr`.
- R11: Transmit-empty clears on `wr_thr`, or on `rd_ident` while 4'b0010 is the reported code. An identification read during a higher code leaves it pending. It is armed again by a rising edge of `tx_empty` or of enable bit 1.
- R12: `irq` is 1 exactly when `ident` differs from 4'b0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_en | input | 4 | Interrupt enable bits |
| line_err | input | 1 | Line status error condition |
| rx_ready | input | 1 | Receive data ready condition (level) |
| rx_timeout | input | 1 | Receive timeout condition |
| tx_empty | input | 1 | Transmit holding register empty |
| modem_chg | input | 1 | Modem status change condition |
| rd_ident | input | 1 | Identification register read strobe |
| rd_lsr | input | 1 | Line status register read strobe |
| rd_rhr | input | 1 | Receive holding register read strobe |
| rd_msr | input | 1 | Modem status register read strobe |
| wr_thr | input | 1 | Transmit holding register write strobe |
| irq | output | 1 | Interrupt output, active high |
| ident | output | 4 | Identification code of the top pending interrupt |

## Verification
The priority encoder is tried with a table of enable masks and condition sets, starting from a fresh reset each time. All sources are raised together with the enables stepped down one class at a time, so that each code is shown to win only when everything above it is masked or absent. Sets with a single source enabled tell gating apart from ordering. Sets where a raised condition has its enable bit cleared show that a masked condition never leaks into the code. Directed sequences then cover service order and the acknowledge rules: a masked lower source coming into view, same-cycle set against clear, a level held high, and the transmit-empty re-arm paths.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int ID_W = 4;
    localparam int EN_W = 4;

    // enable bit positions
    localparam int EN_RX    = 0;
    localparam int EN_TX    = 1;
    localparam int EN_LINE  = 2;
    localparam int EN_MODEM = 3;

    // number of edge-captured sources (line, rx timeout, modem)
    localparam int EDGE_N   = 3;
    localparam int EI_LINE  = 0;
    localparam int EI_TMO   = 1;
    localparam int EI_MODEM = 2;

    typedef enum logic [ID_W-1:0] {
        ID_NONE    = 4'b0001,
        ID_LINE    = 4'b0110,
        ID_RXDATA  = 4'b0100,
        ID_RXTMO   = 4'b1100,
        ID_TXEMPTY = 4'b0010,
        ID_MODEM   = 4'b0000
    } irq_id_e;

    typedef struct packed {
        logic line;
        logic rx_tmo;
        logic rx_data;
        logic tx_empty;
        logic modem;
    } irq_src_t;

    function automatic irq_src_t mask_src(irq_src_t s, logic [EN_W-1:0] en);
        irq_src_t g;
        g.line     = s.line     & en[EN_LINE];
        g.rx_tmo   = s.rx_tmo   & en[EN_RX];
        g.rx_data  = s.rx_data  & en[EN_RX];
        g.tx_empty = s.tx_empty & en[EN_TX];
        g.modem    = s.modem    & en[EN_MODEM];
        return g;
    endfunction

    function automatic irq_id_e top_code(irq_src_t g);
        if (g.line)          return ID_LINE;
        else if (g.rx_tmo)   return ID_RXTMO;
        else if (g.rx_data)  return ID_RXDATA;
        else if (g.tx_empty) return ID_TXEMPTY;
        else if (g.modem)    return ID_MODEM;
        else                 return ID_NONE;
    endfunction

endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] cond,
    input  logic [N-1:0] ack,
    output logic [N-1:0] pend
);
    logic [N-1:0] prev_q;

    for (genvar i = 0; i < N; i++) begin : g_src
        logic rise;
        assign rise = cond[i] & ~prev_q[i];

        always_ff @(posedge clk) begin
            if (rst) begin
                prev_q[i] <= cond[i];
                pend[i]   <= 1'b0;
            end else begin
                prev_q[i] <= cond[i];
                if (rise)
                    pend[i] <= 1'b1;
                else if (ack[i])
                    pend[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/irq_tx_latch.sv
module irq_tx_latch (
    input  logic clk,
    input  logic rst,
    input  logic en_bit,
    input  logic tx_empty,
    input  logic wr_thr,
    input  logic rd_ident,
    input  logic reported,
    output logic pend
);
    logic prev_empty_q;
    logic prev_en_q;
    logic arm;
    logic drop;

    assign arm  = (tx_empty & ~prev_empty_q) | (en_bit & ~prev_en_q);
    assign drop = wr_thr | (rd_ident & reported);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_empty_q <= tx_empty;
            prev_en_q    <= en_bit;
            pend         <= 1'b1;
        end else begin
            prev_empty_q <= tx_empty;
            prev_en_q    <= en_bit;
            if (arm)
                pend <= 1'b1;
            else if (drop)
                pend <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
    import uart_irq_pkg::*;
(
    input  irq_src_t              raw,
    input  logic     [EN_W-1:0]   en,
    output irq_id_e               code,
    output logic                  any
);
    irq_src_t gated;

    always_comb begin
        gated = mask_src(raw, en);
        code  = top_code(gated);
        any   = |gated;
    end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [EN_W-1:0]   irq_en,
    input  logic              line_err,
    input  logic              rx_ready,
    input  logic              rx_timeout,
    input  logic              tx_empty,
    input  logic              modem_chg,
    input  logic              rd_ident,
    input  logic              rd_lsr,
    input  logic              rd_rhr,
    input  logic              rd_msr,
    input  logic              wr_thr,
    output logic              irq,
    output logic [ID_W-1:0]   ident
);
    logic [EDGE_N-1:0] edge_cond;
    logic [EDGE_N-1:0] edge_ack;
    logic [EDGE_N-1:0] edge_pend;
    logic              tx_pend;
    logic              tx_reported;
    irq_src_t          raw;
    irq_id_e           code;

    always_comb begin
        edge_cond           = '0;
        edge_cond[EI_LINE]  = line_err;
        edge_cond[EI_TMO]   = rx_timeout;
        edge_cond[EI_MODEM] = modem_chg;
        edge_ack            = '0;
        edge_ack[EI_LINE]   = rd_lsr;
        edge_ack[EI_TMO]    = rd_rhr;
        edge_ack[EI_MODEM]  = rd_msr;
    end

    irq_edge_latch #(.N(EDGE_N)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .cond (edge_cond),
        .ack  (edge_ack),
        .pend (edge_pend)
    );

    assign tx_reported = (code == ID_TXEMPTY);

    irq_tx_latch u_tx (
        .clk      (clk),
        .rst      (rst),
        .en_bit   (irq_en[EN_TX]),
        .tx_empty (tx_empty),
        .wr_thr   (wr_thr),
        .rd_ident (rd_ident),
        .reported (tx_reported),
        .pend     (tx_pend)
    );

    always_comb begin
        raw.line     = edge_pend[EI_LINE];
        raw.rx_tmo   = edge_pend[EI_TMO];
        raw.rx_data  = rx_ready;
        raw.tx_empty = tx_pend & tx_empty;
        raw.modem    = edge_pend[EI_MODEM];
    end

    irq_prio_enc u_enc (
        .raw  (raw),
        .en   (irq_en),
        .code (code),
        .any  (irq)
    );

    assign ident = code;
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk (
    input logic       clk,
    input logic       rst,
    input logic [3:0] irq_en,
    input logic       line_err,
    input logic       rx_ready,
    input logic       tx_empty,
    input logic       rd_ident,
    input logic       rd_lsr,
    input logic       rd_msr,
    input logic       wr_thr,
    input logic       irq,
    input logic [3:0] ident
);
    // R12
    irq_matches_ident_chk: assert property (@(posedge clk) disable iff (rst)
        irq == (ident != 4'b0001));

    // R2
    all_masked_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_en == 4'b0000) |-> (ident == 4'b0001));

    // R4
    rxdata_code_chk: assert property (@(posedge clk) disable iff (rst)
        (ident == 4'b0100) |-> (rx_ready && irq_en[0]));

    // R5
    rxtmo_enable_chk: assert property (@(posedge clk) disable iff (rst)
        (ident == 4'b1100) |-> irq_en[0]);

    // R7
    modem_enable_chk: assert property (@(posedge clk) disable iff (rst)
        (ident == 4'b0000) |-> irq_en[3]);

    // R6
    tx_code_chk: assert property (@(posedge clk) disable iff (rst)
        (ident == 4'b0010) |-> (tx_empty && irq_en[1]));

    // R8
    line_capture_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(line_err) && irq_en[2]) |=> (!irq_en[2] || ident == 4'b0110));

    // R8
    line_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_lsr && $stable(line_err)) |=> (ident != 4'b0110));

    // R11
    tx_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ((wr_thr || (rd_ident && ident == 4'b0010)) && $stable(tx_empty) && $stable(irq_en))
        |=> (ident != 4'b0010));
endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .irq_en   (irq_en),
    .line_err (line_err),
    .rx_ready (rx_ready),
    .tx_empty (tx_empty),
    .rd_ident (rd_ident),
    .rd_lsr   (rd_lsr),
    .rd_msr   (rd_msr),
    .wr_thr   (wr_thr),
    .irq      (irq),
    .ident    (ident)
);

// File: tb/uart_irq_ident_test.sv
module uart_irq_ident_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] irq_en = '0;
    logic       line_err = 0, rx_ready = 0, rx_timeout = 0, tx_empty = 0, modem_chg = 0;
    logic       rd_ident = 0, rd_lsr = 0, rd_rhr = 0, rd_msr = 0, wr_thr = 0;
    logic       irq;
    logic [3:0] ident;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    uart_irq_ident uut (
        .clk(clk), .rst(rst), .irq_en(irq_en),
        .line_err(line_err), .rx_ready(rx_ready), .rx_timeout(rx_timeout),
        .tx_empty(tx_empty), .modem_chg(modem_chg),
        .rd_ident(rd_ident), .rd_lsr(rd_lsr), .rd_rhr(rd_rhr), .rd_msr(rd_msr),
        .wr_thr(wr_thr), .irq(irq), .ident(ident)
    );

    // {en[3:0], line, rxrdy, tmo, txe, modem, expected ident[3:0]}
    localparam int NV = 11;
    localparam logic [12:0] VEC [NV] = '{
        {4'b0000, 5'b11111, 4'b0001},  // R2 everything masked
        {4'b1111, 5'b11111, 4'b0110},  // R3 line status wins
        {4'b1011, 5'b11111, 4'b1100},  // R5 timeout over data
        {4'b1011, 5'b01011, 4'b0100},  // R4 data ready
        {4'b1011, 5'b00011, 4'b0010},  // R6 transmit empty
        {4'b1011, 5'b00001, 4'b0000},  // R7 modem
        {4'b1000, 5'b11111, 4'b0000},  // R7 only modem enabled
        {4'b0010, 5'b11111, 4'b0010},  // R6 only tx enabled
        {4'b0100, 5'b01111, 4'b0001},  // R2 line enabled, absent
        {4'b0001, 5'b00100, 4'b1100},  // R5 timeout alone
        {4'b1110, 5'b01100, 4'b0001}   // R2 rx disabled
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [3:0] exp);
        logic exp_irq;
        exp_irq = (exp != 4'b0001);
        compared++;
        if (ident !== exp || irq !== exp_irq) begin
            mismatched++;
            $display("FAIL %s: ident=%b irq=%b expected ident=%b irq=%b",
                     req, ident, irq, exp, exp_irq);
        end
    endtask

    task automatic clear_inputs();
        irq_en = '0; line_err = 0; rx_ready = 0; rx_timeout = 0;
        tx_empty = 0; modem_chg = 0;
        rd_ident = 0; rd_lsr = 0; rd_rhr = 0; rd_msr = 0; wr_thr = 0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick();
        tick();
        rst = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        clear_inputs();

        // R1 reset state
        irq_en = 4'b1111;
        do_reset();
        check("R1 during/after reset", 4'b0001);
        tick();
        check("R1 idle", 4'b0001);

        // vector table
        for (int i = 0; i < NV; i++) begin
            clear_inputs();
            do_reset();
            {irq_en, line_err, rx_ready, rx_timeout, tx_empty, modem_chg} = VEC[i][12:4];
            tick();
            check($sformatf("R2-table vec %0d", i), VEC[i][3:0]);
        end

        // R6 transmit-empty straight after reset
        clear_inputs();
        irq_en = 4'b0010; tx_empty = 1;
        do_reset();
        check("R6 tx empty after reset", 4'b0010);

        // R11 identification read clears
        rd_ident = 1; tick(); rd_ident = 0; tick();
        check("R11 ident read clears", 4'b0001);
        // R11 re-arm by enable rise
        irq_en = 4'b0000; tick(); irq_en = 4'b0010; tick();
        check("R11 enable rise re-arms", 4'b0010);
        // R11 write clears
        wr_thr = 1; tick(); wr_thr = 0; tick();
        check("R11 thr write clears", 4'b0001);
        // R11 re-arm by empty rise
        tx_empty = 0; tick(); tx_empty = 1; tick();
        check("R11 empty rise re-arms", 4'b0010);
        // R11 read during higher code keeps it
        irq_en = 4'b0011; rx_ready = 1; tick();
        check("R4 data over tx", 4'b0100);
        rd_ident = 1; tick(); rd_ident = 0; rx_ready = 0; tick();
        check("R11 read under higher code keeps tx", 4'b0010);

        // R8 line status capture and clear
        clear_inputs();
        do_reset();
        irq_en = 4'b0101; line_err = 1; rx_ready = 1; tick();
        check("R8 line capture", 4'b0110);
        rd_lsr = 1; tick(); rd_lsr = 0; tick();
        check("R3 lower source visible after service", 4'b0100);
        rx_ready = 0; tick();
        check("R8 held level no recapture", 4'b0001);
        line_err = 0; tick(); line_err = 1; rd_lsr = 1; tick(); rd_lsr = 0; tick();
        check("R8 edge wins over read", 4'b0110);

        // R9 modem
        clear_inputs();
        do_reset();
        irq_en = 4'b1000; modem_chg = 1; tick();
        check("R9 modem capture", 4'b0000);
        modem_chg = 0; rd_msr = 1; tick(); rd_msr = 0; tick();
        check("R9 modem read clears", 4'b0001);

        // R10 timeout
        clear_inputs();
        do_reset();
        irq_en = 4'b0001; rx_ready = 1; rx_timeout = 1; tick();
        check("R10 timeout capture", 4'b1100);
        rx_timeout = 0; rd_rhr = 1; tick(); rd_rhr = 0; tick();
        check("R10 rhr read clears timeout", 4'b0100);

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #1000000;
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule